// File: doc/BRIEF.md
# Escaped Command Stream Register Decoder

This block sits at the receiving end of a byte stream of display controller commands. Each command opens with an escape byte and an opcode. The decoder accepts one byte per clock over a valid/ready interface. It recognises two commands. The first is a four-byte register write aimed at a 256-entry, 8-bit video register file. The second is a nine-byte copy command. For a copy, the decoder only reports the fields on a strobed output and leaves the actual pixel move to other logic.

Register writes always land in a shadow file. While the file is unlocked they also land in the live file at once. A lock command freezes the live file, so a whole display mode can be staged. A later unlock command copies the entire shadow file into the live file in one cycle and raises a commit pulse, so the timing generator never sees a half-written mode.

Several values are decoded from the live file and exported:
- the output blanking code, with sync-active and power-down flags;
- the colour depth selection;
- two 24-bit plane base pointers.

Bytes that arrive outside a command are dropped. An unknown opcode sends the decoder back to idle, and it waits for the next escape byte.

Top module: `cmd_stream_regdec`

## Requirements
- R1: `in_ready` is high in every cycle, including during reset recovery, so a byte is taken in every cycle that `in_valid` is high.
- R2: While idle, any accepted byte other than the escape value 0xAF is dropped with no effect on registers, outputs or decoder state.
- R3: The sequence 0xAF, 0x20, address, data writes data to the shadow entry at that address. While unlocked, it also writes the live entry, which is readable on `rd_data` (combinational read at `rd_addr`) from the cycle after the data byte is accepted.
- R4: A register write of 0x00 to address 0xFF sets `regs_locked`. While locked, register writes change no live entry and no decoded output.
- R5: A register write of 0xFF to address 0xFF copies every shadow entry to the live file in one cycle. In the cycle after the data byte it raises `commit_pulse` for exactly one cycle and clears `regs_locked`.
- R6: `blank_code` equals live register 0x1F. `sync_active` is high only for code 0x00 and `power_down` only for code 0x07; 0x01 (blank, powered) and 0x05 (standby) drive both flags low.
- R7: `base16_addr` is {live 0x20, live 0x21, live 0x22} and `base8_addr` is {live 0x26, live 0x27, live 0x28}, with the lower address as the most significant byte.
- R8: `depth_16bpp` is high exactly when live register 0x00 holds zero.
- R9: The sequence 0xAF, 0x6A, followed by seven bytes (a 3-byte source address MSB first, a count byte, and a 3-byte destination address MSB first), raises `copy_stb` for one cycle after the ninth byte is accepted. The fields are presented on `copy_src`, `copy_count` and `copy_dst`. Payload bytes are never decoded as commands, even when they equal 0xAF.
- R10: Any opcode other than 0x20 or 0x6A returns the decoder to idle with no side effect, and the next 0xAF starts a new command.
- R11: After reset every live and shadow entry is zero, the file is unlocked, and `commit_pulse` and `copy_stb` are low.
- R12: Cycles with `in_valid` low have no effect, so a command may be spread over non-consecutive cycles.
- R13: A write to address 0xFF with any value other than 0x00 or 0xFF changes neither the lock state nor any register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Command byte present |
| in_data | input | 8 | Command byte |
| in_ready | output | 1 | Byte accepted (always high) |
| rd_addr | input | 8 | Live register read address |
| rd_data | output | 8 | Live register contents at `rd_addr` |
| regs_locked | output | 1 | Live file frozen, writes staged in shadow |
| commit_pulse | output | 1 | One-cycle pulse after an unlock commit |
| blank_code | output | 8 | Live blanking control register |
| sync_active | output | 1 | Blanking code is 0x00 |
| power_down | output | 1 | Blanking code is 0x07 |
| depth_16bpp | output | 1 | Colour depth register selects 16 bpp |
| base16_addr | output | 24 | 16-bpp plane base pointer |
| base8_addr | output | 24 | 8-bpp plane base pointer |
| copy_stb | output | 1 | Copy command fields valid for one cycle |
| copy_src | output | 24 | Copy source address |
| copy_count | output | 8 | Copy pixel count |
| copy_dst | output | 24 | Copy destination address |

## Verification
Register writes are driven back to back and with idle gaps between bytes, which shows that acceptance depends only on `in_valid`. Stray bytes without an escape, and an unknown opcode followed by bytes that would form a valid write, show that nothing leaks through outside a recognised command. A lock, a batch of staged writes (including a spurious control value to 0xFF), then an unlock shows the live outputs frozen and then updated all at once with a single commit pulse. Copy commands whose payload holds escape and write-opcode values show that the payload is consumed by byte count and not decoded.

// File: rtl/csd_pkg.sv
package csd_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_OPCODE,
      ST_WADDR,
      ST_WDATA,
      ST_COPY
   } dec_state_t;

   localparam int unsigned BYTE_W       = 8;
   localparam logic [7:0]  ESC_BYTE     = 8'hAF;
   localparam logic [7:0]  OPC_REGWR    = 8'h20;
   localparam logic [7:0]  OPC_COPY     = 8'h6A;
   localparam logic [7:0]  CTL_ADDR     = 8'hFF;
   localparam logic [7:0]  CTL_LOCK     = 8'h00;
   localparam logic [7:0]  CTL_UNLOCK   = 8'hFF;
endpackage

// File: rtl/csd_parser.sv
module csd_parser
   import csd_pkg::*;
#(
   parameter int unsigned ADDR_W    = 8,
   parameter int unsigned PTR_BYTES = 3,
   parameter logic [7:0]  ESC       = ESC_BYTE,
   parameter logic [7:0]  OP_WR     = OPC_REGWR,
   parameter logic [7:0]  OP_CP     = OPC_COPY
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        in_valid,
   input  logic [BYTE_W-1:0]           in_data,
   output logic                        wr_en,
   output logic [ADDR_W-1:0]           wr_addr,
   output logic [BYTE_W-1:0]           wr_data,
   output logic                        copy_stb,
   output logic [PTR_BYTES*BYTE_W-1:0] copy_src,
   output logic [BYTE_W-1:0]           copy_count,
   output logic [PTR_BYTES*BYTE_W-1:0] copy_dst
);
   localparam int unsigned PTR_W      = PTR_BYTES * BYTE_W;
   localparam int unsigned COPY_BYTES = 2 * PTR_BYTES + 1;
   localparam int unsigned HOLD_W     = (COPY_BYTES - 1) * BYTE_W;
   localparam int unsigned CNT_W      = $clog2(COPY_BYTES);
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(COPY_BYTES - 1);

   initial begin
      assert (ADDR_W == BYTE_W) else $fatal(1, "address byte must fill ADDR_W");
      assert (PTR_BYTES >= 1) else $fatal(1, "PTR_BYTES must be positive");
   end

   dec_state_t               st_q;
   logic [ADDR_W-1:0]        addr_q;
   logic [CNT_W-1:0]         cnt_q;
   logic [HOLD_W-1:0]        hold_q;
   logic [COPY_BYTES*BYTE_W-1:0] full_cmd;

   assign full_cmd = {hold_q, in_data};
   assign wr_en    = in_valid && (st_q == ST_WDATA);
   assign wr_addr  = addr_q;
   assign wr_data  = in_data;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q       <= ST_IDLE;
         addr_q     <= '0;
         cnt_q      <= '0;
         hold_q     <= '0;
         copy_stb   <= 1'b0;
         copy_src   <= '0;
         copy_count <= '0;
         copy_dst   <= '0;
      end else begin
         copy_stb <= 1'b0;
         if (in_valid) begin
            unique case (st_q)
               ST_IDLE: begin
                  if (in_data == ESC) st_q <= ST_OPCODE;
               end
               ST_OPCODE: begin
                  if (in_data == OP_WR) begin
                     st_q <= ST_WADDR;
                  end else if (in_data == OP_CP) begin
                     st_q  <= ST_COPY;
                     cnt_q <= '0;
                  end else begin
                     st_q <= ST_IDLE;
                  end
               end
               ST_WADDR: begin
                  addr_q <= in_data;
                  st_q   <= ST_WDATA;
               end
               ST_WDATA: begin
                  st_q <= ST_IDLE;
               end
               ST_COPY: begin
                  hold_q <= full_cmd[HOLD_W-1:0];
                  cnt_q  <= cnt_q + 1'b1;
                  if (cnt_q == CNT_LAST) begin
                     st_q       <= ST_IDLE;
                     copy_stb   <= 1'b1;
                     copy_src   <= full_cmd[COPY_BYTES*BYTE_W-1 -: PTR_W];
                     copy_count <= full_cmd[PTR_W +: BYTE_W];
                     copy_dst   <= full_cmd[PTR_W-1:0];
                  end
               end
               default: st_q <= ST_IDLE;
            endcase
         end
      end
   end

   // R2
   idle_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_IDLE && in_valid && in_data != ESC) |=> (st_q == ST_IDLE));

   // R12
   stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!in_valid) |=> $stable(st_q) && $stable(addr_q) && $stable(cnt_q));

   // R9
   copy_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      copy_stb |=> !copy_stb);
endmodule

// File: rtl/csd_regbank.sv
module csd_regbank
   import csd_pkg::*;
#(
   parameter int unsigned ADDR_W      = 8,
   parameter int unsigned PTR_BYTES   = 3,
   parameter int unsigned BLANK_ADDR  = 'h1F,
   parameter int unsigned DEPTH_ADDR  = 'h00,
   parameter int unsigned BASE16_ADDR = 'h20,
   parameter int unsigned BASE8_ADDR  = 'h26,
   parameter logic [7:0]  LOCK_ADDR   = CTL_ADDR
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        wr_en,
   input  logic [ADDR_W-1:0]           wr_addr,
   input  logic [BYTE_W-1:0]           wr_data,
   input  logic [ADDR_W-1:0]           rd_addr,
   output logic [BYTE_W-1:0]           rd_data,
   output logic                        locked,
   output logic                        commit,
   output logic [BYTE_W-1:0]           blank_o,
   output logic                        depth16_o,
   output logic [PTR_BYTES*BYTE_W-1:0] base16_o,
   output logic [PTR_BYTES*BYTE_W-1:0] base8_o
);
   localparam int unsigned DEPTH = 1 << ADDR_W;

   initial begin
      assert (BASE16_ADDR + PTR_BYTES <= DEPTH) else $fatal(1, "base16 out of range");
      assert (BASE8_ADDR + PTR_BYTES <= DEPTH) else $fatal(1, "base8 out of range");
      assert (BLANK_ADDR < DEPTH && DEPTH_ADDR < DEPTH) else $fatal(1, "ctl out of range");
   end

   logic [BYTE_W-1:0] shadow_q [DEPTH];
   logic [BYTE_W-1:0] live_q   [DEPTH];
   logic              locked_q;
   logic              commit_q;
   logic              is_ctl;
   logic              lock_now;
   logic              unlock_now;

   assign is_ctl     = (wr_addr == ADDR_W'(LOCK_ADDR));
   assign lock_now   = wr_en && is_ctl && (wr_data == CTL_LOCK);
   assign unlock_now = wr_en && is_ctl && (wr_data == CTL_UNLOCK);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) begin
            shadow_q[i] <= '0;
            live_q[i]   <= '0;
         end
         locked_q <= 1'b0;
         commit_q <= 1'b0;
      end else begin
         commit_q <= unlock_now;
         if (lock_now) locked_q <= 1'b1;
         if (unlock_now) begin
            locked_q <= 1'b0;
            for (int i = 0; i < DEPTH; i++) live_q[i] <= shadow_q[i];
         end
         if (wr_en && !is_ctl) begin
            shadow_q[wr_addr] <= wr_data;
            if (!locked_q) live_q[wr_addr] <= wr_data;
         end
      end
   end

   assign rd_data   = live_q[rd_addr];
   assign locked    = locked_q;
   assign commit    = commit_q;
   assign blank_o   = live_q[BLANK_ADDR];
   assign depth16_o = (live_q[DEPTH_ADDR] == '0);

   for (genvar g = 0; g < PTR_BYTES; g++) begin : g_ptr
      localparam int unsigned SLOT = (PTR_BYTES - 1 - g) * BYTE_W;
      assign base16_o[SLOT +: BYTE_W] = live_q[BASE16_ADDR + g];
      assign base8_o[SLOT +: BYTE_W]  = live_q[BASE8_ADDR + g];
   end

   // R4
   live_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (locked_q && !unlock_now) |=> ($stable(blank_o) && $stable(base16_o)
                                     && $stable(base8_o) && $stable(depth16_o)));

   // R5
   commit_unlocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
      commit_q |-> !locked_q);

   // R5
   commit_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      commit_q |=> !commit_q);
endmodule

// File: rtl/cmd_stream_regdec.sv
module cmd_stream_regdec
   import csd_pkg::*;
#(
   parameter int unsigned ADDR_W    = 8,
   parameter int unsigned PTR_BYTES = 3
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        in_valid,
   input  logic [7:0]                  in_data,
   output logic                        in_ready,
   input  logic [ADDR_W-1:0]           rd_addr,
   output logic [7:0]                  rd_data,
   output logic                        regs_locked,
   output logic                        commit_pulse,
   output logic [7:0]                  blank_code,
   output logic                        sync_active,
   output logic                        power_down,
   output logic                        depth_16bpp,
   output logic [PTR_BYTES*8-1:0]      base16_addr,
   output logic [PTR_BYTES*8-1:0]      base8_addr,
   output logic                        copy_stb,
   output logic [PTR_BYTES*8-1:0]      copy_src,
   output logic [7:0]                  copy_count,
   output logic [PTR_BYTES*8-1:0]      copy_dst
);
   localparam logic [7:0] BLANK_ON   = 8'h00;
   localparam logic [7:0] BLANK_OFF  = 8'h07;

   logic              wr_en;
   logic [ADDR_W-1:0] wr_addr;
   logic [7:0]        wr_data;

   assign in_ready = 1'b1;

   csd_parser #(.ADDR_W(ADDR_W), .PTR_BYTES(PTR_BYTES)) u_parser (
      .clk        (clk),
      .rst_n      (rst_n),
      .in_valid   (in_valid),
      .in_data    (in_data),
      .wr_en      (wr_en),
      .wr_addr    (wr_addr),
      .wr_data    (wr_data),
      .copy_stb   (copy_stb),
      .copy_src   (copy_src),
      .copy_count (copy_count),
      .copy_dst   (copy_dst)
   );

   csd_regbank #(.ADDR_W(ADDR_W), .PTR_BYTES(PTR_BYTES)) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .wr_addr   (wr_addr),
      .wr_data   (wr_data),
      .rd_addr   (rd_addr),
      .rd_data   (rd_data),
      .locked    (regs_locked),
      .commit    (commit_pulse),
      .blank_o   (blank_code),
      .depth16_o (depth_16bpp),
      .base16_o  (base16_addr),
      .base8_o   (base8_addr)
   );

   assign sync_active = (blank_code == BLANK_ON);
   assign power_down  = (blank_code == BLANK_OFF);

   // R6
   blank_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(sync_active && power_down));
endmodule

// File: tb/sim_cmd_stream_regdec.sv
module sim_cmd_stream_regdec;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [7:0]  in_data = '0;
   logic        in_ready;
   logic [7:0]  rd_addr = '0;
   logic [7:0]  rd_data;
   logic        regs_locked, commit_pulse, sync_active, power_down, depth_16bpp;
   logic [7:0]  blank_code, copy_count;
   logic [23:0] base16_addr, base8_addr, copy_src, copy_dst;
   logic        copy_stb;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   logic [7:0]  m_live [256];
   logic [7:0]  m_shadow [256];
   bit          m_locked = 0;
   logic [55:0] exp_q [$];

   always #4 clk = ~clk;

   cmd_stream_regdec u0 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
      .in_ready(in_ready), .rd_addr(rd_addr), .rd_data(rd_data),
      .regs_locked(regs_locked), .commit_pulse(commit_pulse),
      .blank_code(blank_code), .sync_active(sync_active), .power_down(power_down),
      .depth_16bpp(depth_16bpp), .base16_addr(base16_addr), .base8_addr(base8_addr),
      .copy_stb(copy_stb), .copy_src(copy_src), .copy_count(copy_count),
      .copy_dst(copy_dst));

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic put(input logic [7:0] b);
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = b;
   endtask

   task automatic finish_cmd();
      @(negedge clk);
      in_valid = 1'b0;
      in_data  = 8'h00;
      #1;
   endtask

   task automatic model_wr(input logic [7:0] a, input logic [7:0] d);
      if (a == 8'hFF) begin
         if (d == 8'h00) m_locked = 1;
         else if (d == 8'hFF) begin
            m_locked = 0;
            for (int i = 0; i < 256; i++) m_live[i] = m_shadow[i];
         end
      end else begin
         m_shadow[a] = d;
         if (!m_locked) m_live[a] = d;
      end
   endtask

   task automatic write_reg(input logic [7:0] a, input logic [7:0] d);
      put(8'hAF); put(8'h20); put(a); put(d);
      finish_cmd();
      model_wr(a, d);
   endtask

   task automatic check_reg(input string req, input logic [7:0] a);
      rd_addr = a;
      #1;
      chk(req, rd_data, m_live[a]);
   endtask

   task automatic send_copy(input logic [23:0] s, input logic [7:0] n, input logic [23:0] d);
      exp_q.push_back({s, n, d});
      put(8'hAF); put(8'h6A);
      put(s[23:16]); put(s[15:8]); put(s[7:0]);
      put(n);
      put(d[23:16]); put(d[15:8]); put(d[7:0]);
      finish_cmd();
   endtask

   // scoreboard monitor for copy strobes, plus R1 ready watch
   int ready_bad = 0;
   always @(negedge clk) begin
      if (rst_n && !in_ready) ready_bad++;
      if (rst_n && copy_stb) begin
         if (exp_q.size() == 0) begin
            chk("R9 unexpected strobe", 32'd1, 32'd0);
         end else begin
            logic [55:0] e;
            e = exp_q.pop_front();
            chk("R9 copy src", {8'h0, copy_src}, {8'h0, e[55:32]});
            chk("R9 copy count", {24'h0, copy_count}, {24'h0, e[31:24]});
            chk("R9 copy dst", {8'h0, copy_dst}, {8'h0, e[23:0]});
         end
      end
   end

   initial begin
      #(8 * 200000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 256; i++) begin m_live[i] = '0; m_shadow[i] = '0; end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R11 reset state
      chk("R11 locked", regs_locked, 0);
      chk("R11 commit", commit_pulse, 0);
      chk("R11 copy_stb", copy_stb, 0);
      chk("R11 base16", base16_addr, 0);
      chk("R6 reset sync_active", sync_active, 1);
      chk("R8 reset depth", depth_16bpp, 1);
      check_reg("R11 reg 80", 8'h80);

      // R3 / R6 blank codes
      write_reg(8'h1F, 8'h01);
      chk("R3 blank write", blank_code, 8'h01);
      chk("R6 blank sync", sync_active, 0);
      chk("R6 blank pd", power_down, 0);
      write_reg(8'h1F, 8'h07);
      chk("R6 off pd", power_down, 1);
      write_reg(8'h1F, 8'h05);
      chk("R6 standby pd", power_down, 0);
      chk("R6 standby sync", sync_active, 0);
      write_reg(8'h1F, 8'h00);
      chk("R6 on sync", sync_active, 1);

      // R2 stray bytes while idle
      put(8'h20); put(8'h1F); put(8'h07); put(8'h20); put(8'h1F); put(8'h07);
      finish_cmd();
      chk("R2 stray bytes blank", blank_code, 8'h00);

      // R10 unknown opcode then write-looking bytes
      put(8'hAF); put(8'h55); put(8'h1F); put(8'h07);
      finish_cmd();
      chk("R10 unknown opcode", blank_code, 8'h00);
      write_reg(8'h41, 8'h3C);
      check_reg("R10 resync write", 8'h41);

      // R7 base pointers
      write_reg(8'h20, 8'h12); write_reg(8'h21, 8'h34); write_reg(8'h22, 8'h56);
      write_reg(8'h26, 8'hAB); write_reg(8'h27, 8'hCD); write_reg(8'h28, 8'hEF);
      chk("R7 base16", base16_addr, 24'h123456);
      chk("R7 base8", base8_addr, 24'hABCDEF);

      // R8 depth
      write_reg(8'h00, 8'h01);
      chk("R8 depth 8bpp", depth_16bpp, 0);

      // R4 lock, staged writes
      write_reg(8'hFF, 8'h00);
      chk("R4 locked", regs_locked, 1);
      write_reg(8'h1F, 8'h07);
      write_reg(8'h20, 8'h99);
      write_reg(8'h00, 8'h00);
      chk("R4 blank frozen", blank_code, 8'h00);
      chk("R4 base frozen", base16_addr, 24'h123456);
      chk("R4 depth frozen", depth_16bpp, 0);
      check_reg("R4 reg 20 frozen", 8'h20);
      // R13 spurious control value
      write_reg(8'hFF, 8'h5A);
      chk("R13 still locked", regs_locked, 1);
      chk("R13 no commit", commit_pulse, 0);
      check_reg("R13 reg ff", 8'hFF);

      // R5 unlock commit
      put(8'hAF); put(8'h20); put(8'hFF); put(8'hFF);
      finish_cmd();
      model_wr(8'hFF, 8'hFF);
      chk("R5 commit pulse", commit_pulse, 1);
      chk("R5 unlocked", regs_locked, 0);
      chk("R5 blank live", blank_code, 8'h07);
      chk("R5 base live", base16_addr, 24'h993456);
      chk("R5 depth live", depth_16bpp, 1);
      @(negedge clk); #1;
      chk("R5 pulse width", commit_pulse, 0);

      // R12 gaps between bytes
      put(8'hAF); finish_cmd(); finish_cmd();
      put(8'h20); finish_cmd();
      put(8'h40); finish_cmd(); finish_cmd(); finish_cmd();
      put(8'hA5); finish_cmd();
      model_wr(8'h40, 8'hA5);
      check_reg("R12 gapped write", 8'h40);

      // R9 copy commands
      send_copy(24'h010203, 8'h04, 24'h050607);
      chk("R9 strobe timing", copy_stb, 1);
      @(negedge clk); #1;
      chk("R9 strobe width", copy_stb, 0);
      send_copy(24'hAF20FF, 8'h00, 24'hAF6AAF);
      chk("R9 payload not decoded", regs_locked, 0);
      write_reg(8'h1F, 8'h01);
      chk("R9 idle after copy", blank_code, 8'h01);
      chk("R9 queue drained", exp_q.size(), 0);

      // R1 ready every cycle
      chk("R1 ready", ready_bad, 0);

      // R3 full live file sweep
      for (int i = 0; i < 256; i++) check_reg("R3 sweep", 8'(i));

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule